// File: doc/BRIEF.md
# Instruction cache line valid tracker

This block keeps the bookkeeping for a 512-byte program cache that is split into 32 lines of 16 bytes. The cache data itself lives elsewhere. The host fills the cache through a register window. A line counts as holding valid code only once the last byte of that line has been written. A flush invalidates every line, clears the cache base and deactivates the cache.

The run controller asks the block whether execution may start at a given program counter and program bank. If the cache is active and the counter falls inside the 512-byte span that begins at the cache base, the start is allowed in every case. Otherwise the bank decides. Some bank ranges are always refused. A small range is treated as work RAM and needs the RAM access enable. Every remaining bank is treated as ROM and needs the ROM access enable. When a start request is refused, the block raises a one-cycle reject pulse. The controller uses that pulse to drop its go bit without running any code.

Top module: `icache_valid_tracker`

## Requirements
- R1: After reset the valid mask is zero, the cache base is zero, the cache is inactive (hit is 0) and reject is 0.
- R2: A write strobe whose window offset lies in [0x100, 0x300) and has low nibble 0xF sets the valid bit numbered by offset bits [8:4] on the next clock. Offset 0x10F sets bit 16, 0x2FF sets bit 15 and 0x22F sets bit 2. Other bits keep their value.
- R3: A write inside the window whose low nibble is not 0xF leaves the valid mask unchanged.
- R4: A write with an offset below 0x100, or at 0x300 and above, leaves the valid mask unchanged.
- R5: A flush clears all 32 valid bits, sets the cache base to zero and makes the cache inactive on the next clock. Flush takes priority over a write or a base load in the same cycle.
- R6: A base load stores the given base with its low 4 bits forced to zero and makes the cache active on the next clock.
- R7: The hit output is 1 exactly when the cache is active and base <= pc < base + 512. The compare does not wrap past 0xFFFF. When hit is 1, start-allowed is 1 regardless of bank or enables.
- R8: Without a hit, banks 0x60 to 0x6F and banks 0x74 to 0xFF are never allowed.
- R9: Without a hit, banks 0x70 to 0x73 are allowed only when the RAM access enable is 1. The ROM enable has no effect on them.
- R10: Without a hit, banks 0x00 to 0x5F are allowed only when the ROM access enable is 1. The RAM enable has no effect on them.
- R11: A start request in a cycle where start-allowed is 0 gives reject = 1 for exactly the following cycle. A start request in a cycle where start-allowed is 1 gives reject = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe into the register window |
| wr_addr_i | input | 10 | Host write offset within the window |
| flush_i | input | 1 | Invalidate all lines, clear base, deactivate cache |
| base_ld_i | input | 1 | Load the cache base and activate the cache |
| base_i | input | 16 | Cache base value to load |
| pc_i | input | 16 | Program counter of the requested start |
| bank_i | input | 8 | Program bank of the requested start |
| ram_en_i | input | 1 | Work RAM access enable |
| rom_en_i | input | 1 | ROM access enable |
| start_i | input | 1 | Start request from the run controller |
| valid_o | output | 32 | Per-line valid mask |
| base_o | output | 16 | Current cache base |
| hit_o | output | 1 | Program counter lies inside the active cache span |
| allow_o | output | 1 | Start at pc_i/bank_i is permitted |
| reject_o | output | 1 | One-cycle pulse after a refused start request |

## Verification
A corrupted valid bit is visible on valid_o on the clock after the write that caused it. A wrong line index from the offset decode shows up as a set bit in the wrong position, so the line-16, line-15 and line-2 writes separate bit-slice errors from window-range errors. A stale active flag or base shows up on hit_o and allow_o in the same cycle that pc_i points at the former span. A flipped region boundary shows up only at the edge banks, so the bench probes 0x5F, 0x60, 0x6F, 0x70, 0x73 and 0x74 with each enable set on its own.

// File: rtl/icvt_pkg.sv
package icvt_pkg;
  typedef enum logic [1:0] {
    REGION_ROM  = 2'd0,
    REGION_RAM  = 2'd1,
    REGION_DENY = 2'd2
  } region_e;
endpackage

// File: rtl/icvt_line_mark.sv
module icvt_line_mark #(
  parameter int NUM_LINES  = 32,
  parameter int LINE_BYTES = 16,
  parameter int WIN_W      = 10,
  parameter int WIN_LO     = 'h100,
  parameter int WIN_HI     = 'h300,
  parameter int PC_W       = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [WIN_W-1:0]     wr_addr_i,
  input  logic                 flush_i,
  input  logic                 base_ld_i,
  input  logic [PC_W-1:0]      base_i,
  output logic [NUM_LINES-1:0] valid_o,
  output logic [PC_W-1:0]      base_o,
  output logic                 active_o
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic             in_win;
  logic             last_byte;
  logic [IDX_W-1:0] line_idx;

  assign in_win    = (wr_addr_i >= WIN_W'(WIN_LO)) && (wr_addr_i < WIN_W'(WIN_HI));
  assign last_byte = &wr_addr_i[OFS_W-1:0];
  assign line_idx  = wr_addr_i[OFS_W+IDX_W-1:OFS_W];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic set_line;
    assign set_line = wr_en_i && in_win && last_byte && (line_idx == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       valid_o[g] <= 1'b0;
      else if (flush_i)  valid_o[g] <= 1'b0;
      else if (set_line) valid_o[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o   <= '0;
      active_o <= 1'b0;
    end else if (flush_i) begin
      base_o   <= '0;
      active_o <= 1'b0;
    end else if (base_ld_i) begin
      base_o   <= {base_i[PC_W-1:OFS_W], {OFS_W{1'b0}}};
      active_o <= 1'b1;
    end
  end
endmodule

// File: rtl/icvt_hit.sv
module icvt_hit #(
  parameter int NUM_LINES  = 32,
  parameter int LINE_BYTES = 16,
  parameter int PC_W       = 16
) (
  input  logic            active_i,
  input  logic [PC_W-1:0] base_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            hit_o
);
  localparam int SPAN = NUM_LINES * LINE_BYTES;

  logic [PC_W:0] pc_x, lo_x, hi_x;

  // one extra bit so base+span never wraps
  assign pc_x  = {1'b0, pc_i};
  assign lo_x  = {1'b0, base_i};
  assign hi_x  = lo_x + (PC_W+1)'(SPAN);
  assign hit_o = active_i && (pc_x >= lo_x) && (pc_x < hi_x);
endmodule

// File: rtl/icvt_bank_gate.sv
module icvt_bank_gate
  import icvt_pkg::*;
#(
  parameter int BANK_W  = 8,
  parameter int DENY_LO = 'h60,
  parameter int DENY_HI = 'h6F,
  parameter int RAM_LO  = 'h70,
  parameter int RAM_HI  = 'h73
) (
  input  logic [BANK_W-1:0] bank_i,
  output region_e           region_o
);
  always_comb begin
    if (bank_i >= BANK_W'(DENY_LO) && bank_i <= BANK_W'(DENY_HI))
      region_o = REGION_DENY;
    else if (bank_i >= BANK_W'(RAM_LO) && bank_i <= BANK_W'(RAM_HI))
      region_o = REGION_RAM;
    else if (bank_i > BANK_W'(RAM_HI))
      region_o = REGION_DENY;
    else
      region_o = REGION_ROM;
  end
endmodule

// File: rtl/icache_valid_tracker.sv
module icache_valid_tracker
  import icvt_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int LINE_BYTES = 16,
  parameter int WIN_W      = 10,
  parameter int WIN_LO     = 'h100,
  parameter int WIN_HI     = 'h300,
  parameter int PC_W       = 16,
  parameter int BANK_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [WIN_W-1:0]     wr_addr_i,
  input  logic                 flush_i,
  input  logic                 base_ld_i,
  input  logic [PC_W-1:0]      base_i,
  input  logic [PC_W-1:0]      pc_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 ram_en_i,
  input  logic                 rom_en_i,
  input  logic                 start_i,
  output logic [NUM_LINES-1:0] valid_o,
  output logic [PC_W-1:0]      base_o,
  output logic                 hit_o,
  output logic                 allow_o,
  output logic                 reject_o
);
  logic    active;
  region_e region;

  icvt_line_mark #(
    .NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES), .WIN_W(WIN_W),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .PC_W(PC_W)
  ) u_mark (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .flush_i, .base_ld_i, .base_i,
    .valid_o, .base_o, .active_o(active)
  );

  icvt_hit #(.NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES), .PC_W(PC_W)) u_hit (
    .active_i(active), .base_i(base_o), .pc_i, .hit_o
  );

  icvt_bank_gate #(.BANK_W(BANK_W)) u_gate (
    .bank_i, .region_o(region)
  );

  assign allow_o = hit_o
                || ((region == REGION_RAM) && ram_en_i)
                || ((region == REGION_ROM) && rom_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reject_o <= 1'b0;
    else         reject_o <= start_i && !allow_o;
  end
endmodule

// File: rtl/icvt_checker.sv
module icvt_checker #(
  parameter int NUM_LINES = 32,
  parameter int PC_W      = 16,
  parameter int BANK_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 flush_i,
  input logic                 start_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic [NUM_LINES-1:0] valid_o,
  input logic [PC_W-1:0]      base_o,
  input logic                 hit_o,
  input logic                 allow_o,
  input logic                 reject_o
);
  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_o == '0) && (base_o == '0) && !hit_o); // R5

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> ((valid_o & $past(valid_o)) == $past(valid_o))); // R3

  AST_ONE_LINE_PER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> ($countones(valid_o ^ $past(valid_o)) <= 1)); // R2

  AST_HIT_ALLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> allow_o); // R7

  AST_DENY_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_o && ((bank_i >= BANK_W'('h60) && bank_i <= BANK_W'('h6F)) || bank_i >= BANK_W'('h74)))
    |-> !allow_o); // R8

  AST_REJECT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !allow_o) |=> reject_o); // R11

  AST_NO_SPURIOUS_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && !allow_o) |=> !reject_o); // R11
endmodule

bind icache_valid_tracker icvt_checker #(
  .NUM_LINES(NUM_LINES), .PC_W(PC_W), .BANK_W(BANK_W)
) u_checker (
  .clk_i, .rst_ni, .flush_i, .start_i, .bank_i,
  .valid_o, .base_o, .hit_o, .allow_o, .reject_o
);

// File: tb/icache_valid_tracker_tb.sv
module icache_valid_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic        flush = 1'b0;
  logic        base_ld = 1'b0;
  logic [15:0] base_in = '0;
  logic [15:0] pc = '0;
  logic [7:0]  bank = '0;
  logic        ram_en = 1'b0;
  logic        rom_en = 1'b0;
  logic        start = 1'b0;
  logic [31:0] valid;
  logic [15:0] base_q;
  logic        hit, allow, reject;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_mask = '0;

  always #4 clk = ~clk;

  icache_valid_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .flush_i(flush), .base_ld_i(base_ld), .base_i(base_in), .pc_i(pc),
    .bank_i(bank), .ram_en_i(ram_en), .rom_en_i(rom_en), .start_i(start),
    .valid_o(valid), .base_o(base_q), .hit_o(hit), .allow_o(allow),
    .reject_o(reject)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive during one clock, release, sample at the next negedge
  task automatic host_write(input logic [9:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_base(input logic [15:0] b);
    @(negedge clk);
    base_ld = 1'b1; base_in = b;
    @(negedge clk);
    base_ld = 1'b0;
  endtask

  task automatic t_reset;
    pc = 16'h0000; bank = 8'h00;
    #1;
    check("R1 mask", valid, 32'h0);
    check("R1 base", {16'h0, base_q}, 32'h0);
    check("R1 hit", {31'h0, hit}, 32'h0);
    check("R1 reject", {31'h0, reject}, 32'h0);
  endtask

  task automatic t_mark_lines;
    host_write(10'h10F); exp_mask[16] = 1'b1;
    check("R2 line16", valid, exp_mask);
    host_write(10'h2FF); exp_mask[15] = 1'b1;
    check("R2 line15", valid, exp_mask);
    host_write(10'h22F); exp_mask[2] = 1'b1;
    check("R2 line2", valid, exp_mask);
  endtask

  task automatic t_partial_writes;
    host_write(10'h105);
    check("R3 nibble5", valid, exp_mask);
    host_write(10'h1F0);
    check("R3 nibble0", valid, exp_mask);
  endtask

  task automatic t_outside_window;
    host_write(10'h0FF);
    check("R4 below", valid, exp_mask);
    host_write(10'h30F);
    check("R4 above", valid, exp_mask);
    host_write(10'h3FF);
    check("R4 top", valid, exp_mask);
  endtask

  task automatic t_base_and_hit;
    bank = 8'h65; ram_en = 1'b0; rom_en = 1'b0;
    load_base(16'h1234);
    check("R6 base aligned", {16'h0, base_q}, 32'h1230);
    pc = 16'h1230; #1;
    check("R7 low edge hit", {30'h0, hit, allow}, 32'h3);
    pc = 16'h142F; #1;
    check("R7 last byte hit", {30'h0, hit, allow}, 32'h3);
    pc = 16'h1430; #1;
    check("R7 past end", {30'h0, hit, allow}, 32'h0);
    pc = 16'h122F; #1;
    check("R7 before base", {30'h0, hit, allow}, 32'h0);
    load_base(16'hFE05);
    check("R6 base high", {16'h0, base_q}, 32'hFE00);
    pc = 16'hFFFF; #1;
    check("R7 top hit", {31'h0, hit}, 32'h1);
    pc = 16'h0000; #1;
    check("R7 no wrap", {31'h0, hit}, 32'h0);
  endtask

  task automatic t_flush;
    @(negedge clk);
    flush = 1'b1; wr_en = 1'b1; wr_addr = 10'h13F; base_ld = 1'b1; base_in = 16'h4000;
    @(negedge clk);
    flush = 1'b0; wr_en = 1'b0; base_ld = 1'b0;
    exp_mask = '0;
    pc = 16'h0000; bank = 8'h65;
    #1;
    check("R5 mask", valid, 32'h0);
    check("R5 base", {16'h0, base_q}, 32'h0);
    check("R5 inactive", {31'h0, hit}, 32'h0);
  endtask

  task automatic probe(input string req, input logic [7:0] b, input logic ram, input logic rom,
                       input logic exp);
    bank = b; ram_en = ram; rom_en = rom; #1;
    check(req, {31'h0, allow}, {31'h0, exp});
  endtask

  task automatic t_regions;
    @(negedge clk);
    pc = 16'h0000;
    probe("R8 bank60", 8'h60, 1, 1, 0);
    probe("R8 bank6F", 8'h6F, 1, 1, 0);
    probe("R8 bank74", 8'h74, 1, 1, 0);
    probe("R8 bankFF", 8'hFF, 1, 1, 0);
    probe("R9 bank70 ram", 8'h70, 1, 0, 1);
    probe("R9 bank73 ram", 8'h73, 1, 0, 1);
    probe("R9 bank73 rom only", 8'h73, 0, 1, 0);
    probe("R10 bank00 rom", 8'h00, 0, 1, 1);
    probe("R10 bank5F rom", 8'h5F, 0, 1, 1);
    probe("R10 bank5F ram only", 8'h5F, 1, 0, 0);
  endtask

  task automatic t_reject;
    @(negedge clk);
    bank = 8'h60; ram_en = 1'b1; rom_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 refused pulse", {31'h0, reject}, 32'h1);
    @(negedge clk);
    check("R11 pulse ends", {31'h0, reject}, 32'h0);
    bank = 8'h10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 allowed no pulse", {31'h0, reject}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mark_lines();
    t_partial_writes();
    t_outside_window();
    t_base_and_hit();
    t_flush();
    t_regions();
    t_reject();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule